// File: doc/BRIEF.md
# Direct-Page Single-Bit Execution Unit

This unit carries out the single-bit instructions of a small byte-wide processor that work on the lowest 256 bytes of memory. The fetch logic hands it an opcode, a direct address byte, a signed displacement, the accumulator value and the address of the following instruction, together with a one-cycle `start` pulse. The unit then reads the byte through a synchronous memory port. It can test one bit and pick the next program counter, or it can force one bit to 1 or 0 with a read-modify-write. When the instruction has run for its fixed number of cycles, the unit raises `done` for one cycle.

The unit also runs the accumulator bit-test instruction in all six of its addressing forms. This instruction ANDs the accumulator with an operand and updates only the negative and zero flags. Its immediate form takes the operand from the direct address byte input. Its direct form reads the zero-extended address byte. Its remaining forms read at an effective address that is computed outside the unit. The flags and the next program counter are held in registers. They keep their value until a later instruction changes them.

Top module: `dpbit_unit`

## Requirements
- R1: After reset the following are all 0: `busy`, `done`, `mem_re`, `mem_we`, the three flags and `pc_out`.
- R2: Opcodes 0x00, 0x02, …, 0x0E test bit `opcode[3:1]` of the addressed byte and branch when it is 1. A taken branch gives `pc_out` = `pc_seq` + sign-extended `disp`, wrapping modulo 2^PW. A branch not taken gives `pc_out` = `pc_seq`.
- R3: Opcodes 0x01, 0x03, …, 0x0F test bit `opcode[3:1]` in the same way but branch when that bit is 0.
- R4: The test-and-branch forms load `flag_c` with the tested bit and leave `flag_n` and `flag_z` unchanged. They never write memory.
- R5: Opcodes 0x10, 0x12, …, 0x1E write the byte back with bit `opcode[3:1]` set to 1 and every other bit as read. They leave all flags unchanged and give `pc_out` = `pc_seq`.
- R6: Opcodes 0x11, 0x13, …, 0x1F write the byte back with bit `opcode[3:1]` cleared, with the same timing as R5.
- R7: For the bit forms, the read is issued in the start cycle at address {0, `dir_addr`}. The read-modify-write forms issue exactly one write to that same address, two cycles after the start cycle.
- R8: Every test-and-branch and bit-write instruction lasts 5 cycles, counting the start cycle. `done` is high in the fifth cycle only.
- R9: The accumulator bit test (opcode low nibble 0x5) sets `flag_n` to bit 7 of `acc` AND operand, and sets `flag_z` when that AND is 0x00. It leaves `flag_c` unchanged, writes nothing and gives `pc_out` = `pc_seq`.
- R10: The bit-test forms last the following numbers of cycles, including the start cycle:
  - 0xA5 lasts 2 cycles. The operand is `dir_addr` and no read is made.
  - 0xB5 lasts 3 cycles and reads at {0, `dir_addr`}.
  - 0xC5 lasts 4 cycles, 0xD5 lasts 5, 0xE5 lasts 4 and 0xF5 lasts 3. These four read at `ea`.
- R11: The unit ignores `start` while it is busy. It also ignores any opcode not listed in R2 to R10: no access is made and `busy` stays 0.
- R12: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the instruction presented on the operand inputs |
| opcode | input | 8 | Instruction opcode |
| dir_addr | input | 8 | Direct address byte, or the immediate operand for 0xA5 |
| disp | input | 8 | Signed branch displacement |
| ea | input | AW | Effective address for the extended and indexed bit-test forms |
| acc | input | 8 | Accumulator value |
| pc_seq | input | PW | Address of the following instruction |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Read request; data returns on `mem_rdata` in the next cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | Last cycle of the instruction |
| pc_out | output | PW | Next program counter |
| flag_c | output | 1 | Carry flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |

## Verification
The bench builds the unit with its defaults: 16-bit address and program counter, five-cycle bit operations, and the clear variant enabled. With these values the sixteen-bit wrap of a branch target near the top of the address space can be reached. The odd 0x1x opcodes also decode, and the extended forms can drive an effective address whose upper byte differs from zero. The table covers both branch senses, both write senses, and every bit-test form together with its length. Directed cases cover reset, illegal opcodes and a second `start` that arrives mid-instruction.

// File: rtl/dpbit_pkg.sv
`timescale 1ns/1ps
package dpbit_pkg;

   localparam int CYC_W = 3;

   typedef enum logic [1:0] {
      K_NONE   = 2'd0,
      K_BRANCH = 2'd1,
      K_MODIFY = 2'd2,
      K_TEST   = 2'd3
   } kind_e;

   typedef enum logic [1:0] {
      SRC_IMM = 2'd0,
      SRC_DIR = 2'd1,
      SRC_EA  = 2'd2
   } src_e;

   typedef struct packed {
      kind_e             kind;
      src_e              src;
      logic [2:0]        bit_idx;
      logic              sense;
      logic [CYC_W-1:0]  cycles;
   } dec_t;

endpackage

// File: rtl/dpbit_decode.sv
`timescale 1ns/1ps
module dpbit_decode
   import dpbit_pkg::*;
#(
   parameter int BITOP_CYCLES = 5,
   parameter bit CLR_EN       = 1'b1
) (
   input  logic [7:0] opcode_i,
   output dec_t       dec_o
);

   localparam logic [CYC_W-1:0] BCYC = CYC_W'(BITOP_CYCLES);

   logic clr_ok;

   generate
      if (CLR_EN) begin : g_clr_on
         assign clr_ok = 1'b1;
      end else begin : g_clr_off
         assign clr_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      dec_o.kind    = K_NONE;
      dec_o.src     = SRC_DIR;
      dec_o.bit_idx = opcode_i[3:1];
      dec_o.sense   = opcode_i[0];
      dec_o.cycles  = BCYC;
      if (opcode_i[7:4] == 4'h0) begin
         dec_o.kind = K_BRANCH;
      end else if (opcode_i[7:4] == 4'h1) begin
         if (!opcode_i[0] || clr_ok) dec_o.kind = K_MODIFY;
      end else if (opcode_i[3:0] == 4'h5) begin
         unique case (opcode_i[7:4])
            4'hA: begin dec_o.kind = K_TEST; dec_o.src = SRC_IMM; dec_o.cycles = 3'd2; end
            4'hB: begin dec_o.kind = K_TEST; dec_o.src = SRC_DIR; dec_o.cycles = 3'd3; end
            4'hC: begin dec_o.kind = K_TEST; dec_o.src = SRC_EA;  dec_o.cycles = 3'd4; end
            4'hD: begin dec_o.kind = K_TEST; dec_o.src = SRC_EA;  dec_o.cycles = 3'd5; end
            4'hE: begin dec_o.kind = K_TEST; dec_o.src = SRC_EA;  dec_o.cycles = 3'd4; end
            4'hF: begin dec_o.kind = K_TEST; dec_o.src = SRC_EA;  dec_o.cycles = 3'd3; end
            default: dec_o.kind = K_NONE;
         endcase
      end
   end

endmodule

// File: rtl/dpbit_seq.sv
`timescale 1ns/1ps
module dpbit_seq
   import dpbit_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept_i,
   input  logic [CYC_W-1:0] cycles_i,
   output logic             busy_o,
   output logic [CYC_W-1:0] step_o,
   output logic             done_o
);

   logic [CYC_W-1:0] tgt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         step_o <= '0;
         tgt_q  <= '0;
      end else if (accept_i) begin
         busy_o <= 1'b1;
         step_o <= CYC_W'(1);
         tgt_q  <= cycles_i - CYC_W'(1);
      end else if (busy_o) begin
         if (step_o == tgt_q) busy_o <= 1'b0;
         else                 step_o <= step_o + CYC_W'(1);
      end
   end

   assign done_o = busy_o && (step_o == tgt_q);

   // R8: done lasts exactly one cycle
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: the step counter never runs past the final cycle
   p_step_bounded_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (step_o != '0) && (step_o <= tgt_q));

endmodule

// File: rtl/dpbit_alu.sv
`timescale 1ns/1ps
module dpbit_alu #(
   parameter int PW = 16
) (
   input  logic [7:0]    byte_i,
   input  logic [7:0]    acc_i,
   input  logic [7:0]    disp_i,
   input  logic [2:0]    bit_i,
   input  logic          sense_i,
   input  logic [PW-1:0] pc_i,
   output logic          tested_o,
   output logic [PW-1:0] pc_o,
   output logic [7:0]    mod_o,
   output logic [7:0]    and_o
);

   logic [7:0]    mask;
   logic          taken;
   logic [PW-1:0] disp_ext;

   assign mask     = 8'h01 << bit_i;
   assign tested_o = |(byte_i & mask);
   assign taken    = sense_i ? !tested_o : tested_o;
   assign disp_ext = {{(PW-8){disp_i[7]}}, disp_i};
   assign pc_o     = taken ? (pc_i + disp_ext) : pc_i;
   assign mod_o    = sense_i ? (byte_i & ~mask) : (byte_i | mask);
   assign and_o    = acc_i & byte_i;

endmodule

// File: rtl/dpbit_unit.sv
`timescale 1ns/1ps
module dpbit_unit
   import dpbit_pkg::*;
#(
   parameter int AW           = 16,
   parameter int PW           = 16,
   parameter int BITOP_CYCLES = 5,
   parameter bit CLR_EN       = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [7:0]    opcode,
   input  logic [7:0]    dir_addr,
   input  logic [7:0]    disp,
   input  logic [AW-1:0] ea,
   input  logic [7:0]    acc,
   input  logic [PW-1:0] pc_seq,
   output logic [AW-1:0] mem_addr,
   output logic          mem_re,
   output logic          mem_we,
   output logic [7:0]    mem_wdata,
   input  logic [7:0]    mem_rdata,
   output logic          busy,
   output logic          done,
   output logic [PW-1:0] pc_out,
   output logic          flag_c,
   output logic          flag_n,
   output logic          flag_z
);

   localparam int PAD = AW - 8;

   generate
      if (AW < 9) begin : g_bad_aw
         $error("dpbit_unit: AW must be at least 9");
      end
      if (PW < 9) begin : g_bad_pw
         $error("dpbit_unit: PW must be at least 9");
      end
      if (BITOP_CYCLES < 3 || BITOP_CYCLES > 7) begin : g_bad_cyc
         $error("dpbit_unit: BITOP_CYCLES must lie in 3..7");
      end
   endgenerate

   dec_t             dec_in;
   kind_e            kind_q, cur_kind;
   src_e             src_q;
   logic [2:0]       bit_q;
   logic             sense_q;
   logic [7:0]       dir_q, disp_q, acc_q, raw_q, mod_q;
   logic [PW-1:0]    pc_q;
   logic             accept, upd;
   logic [CYC_W-1:0] step;

   logic [7:0]       cur_byte, cur_acc, cur_disp, alu_mod, alu_and;
   logic [2:0]       cur_bit;
   logic             cur_sense, alu_tested;
   logic [PW-1:0]    cur_pc, alu_pc;

   dpbit_decode #(.BITOP_CYCLES(BITOP_CYCLES), .CLR_EN(CLR_EN)) u_dec (
      .opcode_i (opcode),
      .dec_o    (dec_in)
   );

   assign accept = start && !busy && (dec_in.kind != K_NONE);

   dpbit_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .cycles_i (dec_in.cycles),
      .busy_o   (busy),
      .step_o   (step),
      .done_o   (done)
   );

   // operands come straight from the inputs at acceptance, from latches afterwards
   assign cur_kind  = accept ? dec_in.kind    : kind_q;
   assign cur_byte  = accept ? dir_addr       : mem_rdata;
   assign cur_acc   = accept ? acc            : acc_q;
   assign cur_disp  = accept ? disp           : disp_q;
   assign cur_bit   = accept ? dec_in.bit_idx : bit_q;
   assign cur_sense = accept ? dec_in.sense   : sense_q;
   assign cur_pc    = accept ? pc_seq         : pc_q;

   dpbit_alu #(.PW(PW)) u_alu (
      .byte_i   (cur_byte),
      .acc_i    (cur_acc),
      .disp_i   (cur_disp),
      .bit_i    (cur_bit),
      .sense_i  (cur_sense),
      .pc_i     (cur_pc),
      .tested_o (alu_tested),
      .pc_o     (alu_pc),
      .mod_o    (alu_mod),
      .and_o    (alu_and)
   );

   assign upd = (accept && dec_in.src == SRC_IMM) ||
                (busy && step == CYC_W'(1) && src_q != SRC_IMM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q  <= K_NONE;
         src_q   <= SRC_DIR;
         bit_q   <= '0;
         sense_q <= 1'b0;
         dir_q   <= '0;
         disp_q  <= '0;
         acc_q   <= '0;
         pc_q    <= '0;
      end else if (accept) begin
         kind_q  <= dec_in.kind;
         src_q   <= dec_in.src;
         bit_q   <= dec_in.bit_idx;
         sense_q <= dec_in.sense;
         dir_q   <= dir_addr;
         disp_q  <= disp;
         acc_q   <= acc;
         pc_q    <= pc_seq;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_c <= 1'b0;
         flag_n <= 1'b0;
         flag_z <= 1'b0;
         pc_out <= '0;
         raw_q  <= '0;
         mod_q  <= '0;
      end else if (upd) begin
         unique case (cur_kind)
            K_BRANCH: begin
               flag_c <= alu_tested;
               pc_out <= alu_pc;
            end
            K_MODIFY: begin
               raw_q  <= cur_byte;
               mod_q  <= alu_mod;
               pc_out <= cur_pc;
            end
            K_TEST: begin
               flag_n <= alu_and[7];
               flag_z <= (alu_and == 8'h00);
               pc_out <= cur_pc;
            end
            default: ;
         endcase
      end
   end

   assign mem_re    = accept && (dec_in.src != SRC_IMM);
   assign mem_we    = busy && (step == CYC_W'(2)) && (kind_q == K_MODIFY);
   assign mem_wdata = mod_q;

   always_comb begin
      if (busy)                     mem_addr = {{PAD{1'b0}}, dir_q};
      else if (dec_in.src == SRC_EA) mem_addr = ea;
      else                          mem_addr = {{PAD{1'b0}}, dir_addr};
   end

   // R12: a read and a write never share a cycle
   p_rw_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we));

   // R5: only the selected bit may differ between the read and the written byte
   p_rmw_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (((mem_wdata ^ raw_q) & ~(8'h01 << bit_q)) == 8'h00));

   // R5: the flags hold still during a bit write
   p_modify_keeps_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q == K_MODIFY) |=> ($stable(flag_c) && $stable(flag_n) && $stable(flag_z)));

   // R4: a test-and-branch leaves the negative and zero flags alone
   p_branch_keeps_nz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q == K_BRANCH) |=> ($stable(flag_n) && $stable(flag_z)));

   // R9: the accumulator bit test leaves carry alone
   p_test_keeps_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && kind_q == K_TEST) |=> $stable(flag_c));

   // R11: an unknown opcode starts nothing
   p_illegal_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && dec_in.kind == K_NONE) |-> (!mem_re ##1 !busy));

   // R11: a running instruction cannot be aborted or restarted
   p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> (busy && step == $past(step) + CYC_W'(1)));

endmodule

// File: tb/dpbit_unit_test.sv
`timescale 1ns/1ps
module dpbit_unit_test;

   typedef struct packed {
      logic [7:0]  op;
      logic [7:0]  dir;
      logic [7:0]  disp;
      logic [15:0] ea;
      logic [7:0]  acc;
      logic [15:0] pc;
      logic [7:0]  mem;
      logic [15:0] exp_pc;
      logic [7:0]  exp_wd;
      logic [3:0]  exp_cyc;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t TBL [NV] = '{
      '{8'h00, 8'h40, 8'h10, 16'h0000, 8'h00, 16'h0200, 8'h01, 16'h0210, 8'h00, 4'd5},
      '{8'h0F, 8'h41, 8'hF0, 16'h0000, 8'h00, 16'h0200, 8'h7F, 16'h01F0, 8'h00, 4'd5},
      '{8'h0E, 8'h42, 8'h05, 16'h0000, 8'h00, 16'h0300, 8'h7F, 16'h0300, 8'h00, 4'd5},
      '{8'h07, 8'h43, 8'h22, 16'h0000, 8'h00, 16'h0400, 8'h08, 16'h0400, 8'h00, 4'd5},
      '{8'h1A, 8'h80, 8'h00, 16'h0000, 8'h00, 16'h0500, 8'h00, 16'h0500, 8'h20, 4'd5},
      '{8'h1B, 8'h81, 8'h00, 16'h0000, 8'h00, 16'h0500, 8'hFF, 16'h0500, 8'hDF, 4'd5},
      '{8'h10, 8'h82, 8'h00, 16'h0000, 8'h00, 16'h0510, 8'h01, 16'h0510, 8'h01, 4'd5},
      '{8'hA5, 8'h80, 8'h00, 16'h0000, 8'hF0, 16'h0600, 8'h00, 16'h0600, 8'h00, 4'd2},
      '{8'hB5, 8'h22, 8'h00, 16'h0000, 8'h0F, 16'h0602, 8'hF0, 16'h0602, 8'h00, 4'd3},
      '{8'hC5, 8'h00, 8'h00, 16'h1234, 8'hFF, 16'h0605, 8'h7F, 16'h0605, 8'h00, 4'd4},
      '{8'hD5, 8'h00, 8'h00, 16'h0456, 8'h80, 16'h0608, 8'h80, 16'h0608, 8'h00, 4'd5},
      '{8'hE5, 8'h00, 8'h00, 16'h00AB, 8'h01, 16'h060A, 8'h02, 16'h060A, 8'h00, 4'd4},
      '{8'hF5, 8'h00, 8'h00, 16'h00CD, 8'h3C, 16'h060B, 8'h24, 16'h060B, 8'h00, 4'd3},
      '{8'h0C, 8'h44, 8'h7F, 16'h0000, 8'h00, 16'hFFF0, 8'h40, 16'h006F, 8'h00, 4'd5},
      '{8'h1F, 8'h83, 8'h00, 16'h0000, 8'h00, 16'h0700, 8'h80, 16'h0700, 8'h00, 4'd5},
      '{8'h03, 8'h45, 8'h80, 16'h0000, 8'h00, 16'h0100, 8'hFD, 16'h0080, 8'h00, 4'd5}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  opcode = '0, dir_addr = '0, disp = '0, acc = '0;
   logic [15:0] ea = '0, pc_seq = '0;
   logic [15:0] mem_addr;
   logic        mem_re, mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done, flag_c, flag_n, flag_z;
   logic [15:0] pc_out;

   logic [7:0]  mem_val = '0;
   int          rd_cnt = 0, wr_cnt = 0, both_cnt = 0, cyc_cnt = 0;
   logic [15:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;

   int checks = 0, failures = 0;
   logic m_c = 1'b0, m_n = 1'b0, m_z = 1'b0;

   always #2.5 clk = ~clk;

   dpbit_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .dir_addr(dir_addr),
      .disp(disp), .ea(ea), .acc(acc), .pc_seq(pc_seq), .mem_addr(mem_addr),
      .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .pc_out(pc_out),
      .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
   );

   // synchronous memory model: one-cycle read latency
   always @(posedge clk) begin
      cyc_cnt <= cyc_cnt + 1;
      if (mem_re) begin
         mem_rdata <= mem_val;
         rd_cnt    <= rd_cnt + 1;
      end
      if (mem_we) begin
         wr_cnt  <= wr_cnt + 1;
         wr_addr <= mem_addr;
         wr_data <= mem_wdata;
      end
      if (mem_re && mem_we) both_cnt <= both_cnt + 1;
   end

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic run_vec(input vec_t v);
      logic is_br, is_md, is_imm, is_dir;
      logic [15:0] exp_ra;
      logic [7:0]  opnd, res;
      int rd0, wr0, n, we_at;
      is_br  = (v.op[7:4] == 4'h0);
      is_md  = (v.op[7:4] == 4'h1);
      is_imm = (v.op == 8'hA5);
      is_dir = is_br || is_md || (v.op == 8'hB5);
      exp_ra = is_dir ? {8'h00, v.dir} : v.ea;
      @(negedge clk);
      opcode = v.op; dir_addr = v.dir; disp = v.disp; ea = v.ea;
      acc = v.acc; pc_seq = v.pc; mem_val = v.mem; start = 1'b1;
      #1;
      rd0 = rd_cnt; wr0 = wr_cnt;
      chk("R7/R10 read request in start cycle", {31'd0, mem_re}, {31'd0, !is_imm});
      if (!is_imm) chk("R7/R10 read address", {16'd0, mem_addr}, {16'd0, exp_ra});
      @(negedge clk);
      start = 1'b0;
      opcode = 8'h55; dir_addr = 8'hEE; acc = 8'h00; pc_seq = 16'hDEAD; disp = 8'h00;
      n = 1; we_at = 0;
      while (!done && n < 12) begin
         if (mem_we) we_at = n;
         @(negedge clk);
         n++;
      end
      chk("R8/R10 cycles to done", n + 1, {28'd0, v.exp_cyc});
      chk("R2/R3/R5/R9 pc_out", {16'd0, pc_out}, {16'd0, v.exp_pc});
      if (is_br) m_c = v.mem[v.op[3:1]];
      if (!is_br && !is_md) begin
         opnd = is_imm ? v.dir : v.mem;
         res  = v.acc & opnd;
         m_n  = res[7];
         m_z  = (res == 8'h00);
      end
      chk("R4/R9 flag_c", {31'd0, flag_c}, {31'd0, m_c});
      chk("R4/R9 flag_n", {31'd0, flag_n}, {31'd0, m_n});
      chk("R4/R9 flag_z", {31'd0, flag_z}, {31'd0, m_z});
      chk("R7/R10 read count", rd_cnt - rd0, is_imm ? 0 : 1);
      chk("R4/R5/R6/R9 write count", wr_cnt - wr0, is_md ? 1 : 0);
      if (is_md) begin
         chk("R5/R6 write data", {24'd0, wr_data}, {24'd0, v.exp_wd});
         chk("R7 write address", {16'd0, wr_addr}, {16'd0, 8'h00, v.dir});
         chk("R7 write cycle", we_at, 2);
      end
      @(negedge clk);
      chk("R8 done single cycle", {31'd0, done}, 32'd0);
   endtask

   initial begin : watchdog
      while (cyc_cnt < 100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL R8 watchdog expired");
      summary();
   end

   initial begin : main
      int rd0, wr0, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", {31'd0, busy}, 0);
      chk("R1 done", {31'd0, done}, 0);
      chk("R1 mem_re/mem_we", {30'd0, mem_re, mem_we}, 0);
      chk("R1 flags", {29'd0, flag_c, flag_n, flag_z}, 0);
      chk("R1 pc_out", {16'd0, pc_out}, 0);

      for (int i = 0; i < NV; i++) run_vec(TBL[i]);

      // R11: illegal opcodes start nothing
      begin
         logic [7:0] bad [3] = '{8'h55, 8'h20, 8'h95};
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            opcode = bad[k]; dir_addr = 8'h10; start = 1'b1;
            #1;
            chk("R11 illegal opcode no read", {31'd0, mem_re}, 0);
            @(negedge clk);
            start = 1'b0;
            chk("R11 illegal opcode not busy", {31'd0, busy}, 0);
         end
      end

      // R11: start while busy is ignored (bit set running, bit test offered mid-way)
      @(negedge clk);
      opcode = 8'h1A; dir_addr = 8'h84; pc_seq = 16'h0800; mem_val = 8'h00; start = 1'b1;
      #1;
      rd0 = rd_cnt; wr0 = wr_cnt;
      @(negedge clk);
      opcode = 8'hA5; dir_addr = 8'h80; acc = 8'hFF; pc_seq = 16'h0900; start = 1'b1;
      #1;
      chk("R11 no read on busy start", {31'd0, mem_re}, 0);
      @(negedge clk);
      start = 1'b0;
      n = 2;
      while (!done && n < 12) begin @(negedge clk); n++; end
      chk("R11/R8 busy start keeps length", n + 1, 5);
      chk("R11 busy start leaves flag_n", {31'd0, flag_n}, {31'd0, m_n});
      chk("R11 busy start leaves flag_z", {31'd0, flag_z}, {31'd0, m_z});
      chk("R11 pc from first instruction", {16'd0, pc_out}, 32'h0800);
      chk("R11 single read", rd_cnt - rd0, 1);
      chk("R5 single write", wr_cnt - wr0, 1);
      chk("R5 write data", {24'd0, wr_data}, 32'h20);
      @(negedge clk);
      chk("R11 idle after", {31'd0, busy}, 0);
      chk("R12 read and write never together", both_cnt, 0);
      summary();
   end

endmodule